// File: doc/BRIEF.md
# Reconfigurable Redundant Systolic Array

This block is a small output-stationary grid of multiply-accumulate elements whose protection level is picked per layer. Every element keeps its own running sum while row operands ripple rightward and column operands ripple downward. A two-bit mode value, captured when a layer is launched, decides how the grid is used. It can run as independent elements for the most results per layer. It can also be regrouped into pairs that are compared, or into clusters of three or four that are put to a majority vote. Operand-sharing buses make sure every member of a cluster sees exactly the same operand stream.

A controller launches a layer with a one-cycle start pulse that carries the mode and the number of stream beats. It raises busy while operands stream in and pulses done once the sums and the error flags have settled. Results are presented one per group, packed in group order. A dual layer reports a sticky comparator flag for each pair. A triple or quad layer reports a sticky flag for each element that was outvoted. A per-element fault-injection input lets the redundancy be exercised.

Top module: `rra_array`

## Requirements
- R1: After reset, busy and done are low, every result slot and every flag is zero, and res_count reads 24 (independent mode).
- R2: With op_mode 00 (independent), group size is 1 and there are 12 logical columns. The bench streams K terms: at beat t (0-based run cycle after the accepted start), row input r carries A[r][t-r] and column input c carries B[t-c][c], with zero outside 0..K-1. Slot r*LC+c then holds the 20-bit unsigned sum of A[r][k]*B[k][c], where LC is the number of logical columns. Operands are 8-bit unsigned.
- R3: With op_mode 01 (dual), physical columns 2c and 2c+1 form pair c, giving 6 logical columns. Both members take column input c, and inputs 6..11 are ignored. The slot holds the value of the lower-numbered (primary) member, and no element flag is raised.
- R4: In dual mode, pair flag g (pair g being elements 2g and 2g+1, element index row*12+col) is set once the two sums differ in any cycle. It stays set until the next accepted start, even if the sums agree again later.
- R5: With op_mode 10 (triple), three adjacent columns form a group, giving 4 logical columns. The slot holds the value shared by at least two members, or member 0's value when none is shared. Each element whose sum differs from the slot value in any cycle gets its sticky element flag set.
- R6: With op_mode 11 (quad), four adjacent columns form a group, giving 3 logical columns. A value must be shared by at least three members to win, otherwise member 0's value is output. Element flags are set as in R5.
- R7: The mode is captured only by a start that arrives while busy is low. Start pulses and op_mode changes while busy is high have no effect on the running layer.
- R8: Every accepted start clears all sums, operand pipelines and flags, so a new layer, in a new mode or the same one, never carries over earlier values.
- R9: For a start with length L>0, busy is high in the cycle after the start and done is high for exactly one cycle, L+1 cycles after the start edge. Results and flags are final when done is high.
- R10: res_count shows the number of groups for the captured mode (24, 12, 8 or 6). Result slots at and above that count read zero.
- R11: While a layer runs, a set inject bit inverts bit 0 of that element's product for that beat, and only for that element.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Layer launch pulse, honoured only while idle |
| op_mode | input | 2 | Mode for the launched layer (00 independent, 01 dual, 10 triple, 11 quad) |
| len | input | 8 | Number of stream beats in the layer |
| row_a | input | 16 | Row operands, 8 bits per row, row 0 in the low byte |
| col_b | input | 96 | Column operands, 8 bits per logical column, column 0 in the low byte |
| inject | input | 24 | Per-element product bit-0 inversion for fault exercise |
| busy | output | 1 | Layer in progress |
| done | output | 1 | One-cycle completion pulse |
| res_count | output | 5 | Number of valid result slots |
| results | output | 480 | 24 slots of 20 bits, slot 0 in the low bits, packed in group order |
| pair_err | output | 12 | Sticky per-pair comparator flags |
| elem_dis | output | 24 | Sticky per-element vote-disagreement flags |

## Verification
Each of the four modes is first run with random operand matrices and no faults. These runs show whether the operand-sharing buses and the logical-column skew are right, because a wrong bus gives a wrong sum in the checked slot. Junk on the unused column inputs and stray start and mode activity during a run separate real bus isolation and mode capture from mere coincidence. Directed fault patterns then tell the decision rules apart. A pair fault that cancels itself must still leave the sticky flag set. A single outvoted element must not change the triple result. A quad group with two different faults has no three-way majority and must fall back to member 0. Random layers that mix modes and single injections check that flags and sums from one layer never leak into the next.

// File: rtl/rra_pkg.sv
package rra_pkg;

  typedef enum logic [1:0] {
    MD_FULL = 2'b00,
    MD_PAIR = 2'b01,
    MD_TRIO = 2'b10,
    MD_QUAD = 2'b11
  } rra_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RUN,
    ST_FLUSH
  } rra_state_e;

  // members per redundant group for a mode
  function automatic int group_size(input rra_mode_e m);
    case (m)
      MD_PAIR: group_size = 2;
      MD_TRIO: group_size = 3;
      MD_QUAD: group_size = 4;
      default: group_size = 1;
    endcase
  endfunction

  // minimum number of agreeing members for a value to win
  function automatic int win_quorum(input int g);
    win_quorum = g / 2 + 1;
  endfunction

endpackage

// File: rtl/rra_ctrl.sv
module rra_ctrl
  import rra_pkg::*;
#(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [1:0]       op_mode,
  input  logic [LEN_W-1:0] len,
  output rra_mode_e        mode_q,
  output logic             start_acc,
  output logic             pe_en,
  output logic             busy,
  output logic             done
);

  rra_state_e       state;
  logic [LEN_W-1:0] beats_left;

  assign start_acc = start && (state == ST_IDLE);
  assign pe_en     = (state == ST_RUN);
  assign busy      = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      beats_left <= '0;
      mode_q     <= MD_FULL;
      done       <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            mode_q     <= rra_mode_e'(op_mode);
            beats_left <= len;
            state      <= (len == '0) ? ST_FLUSH : ST_RUN;
          end
        end
        ST_RUN: begin
          beats_left <= beats_left - 1'b1;
          if (beats_left == LEN_W'(1)) state <= ST_FLUSH;
        end
        default: begin
          state <= ST_IDLE;
          done  <= 1'b1;
        end
      endcase
    end
  end

  // R7: captured mode cannot move during a layer
  assert_mode_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(mode_q));

  // R9: completion is a single-cycle pulse that ends a busy period
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_after_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(busy) && !busy));

endmodule

// File: rtl/rra_pe.sv
module rra_pe #(
  parameter int DW    = 8,
  parameter int ACC_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             en,
  input  logic             flip,
  input  logic [DW-1:0]    a_in,
  input  logic [DW-1:0]    b_in,
  output logic [DW-1:0]    a_q,
  output logic [DW-1:0]    b_q,
  output logic [ACC_W-1:0] acc
);

  localparam int PW = 2 * DW;

  // product with optional bit-0 inversion, widened to the sum width
  function automatic logic [ACC_W-1:0] mac_term(input logic [DW-1:0] a,
                                                input logic [DW-1:0] b,
                                                input logic f);
    logic [PW-1:0] p;
    p = PW'(a) * PW'(b);
    p[0] = p[0] ^ f;
    mac_term = ACC_W'(p);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      a_q <= '0;
      b_q <= '0;
      acc <= '0;
    end else if (en) begin
      a_q <= a_in;
      b_q <= b_in;
      acc <= acc + mac_term(a_in, b_in, flip);
    end
  end

endmodule

// File: rtl/rra_voter.sv
module rra_voter
  import rra_pkg::*;
#(
  parameter int G = 3,
  parameter int W = 20
) (
  input  logic [G*W-1:0] vals,
  output logic [W-1:0]   voted,
  output logic [G-1:0]   disagree
);

  localparam int QUORUM = win_quorum(G);
  localparam int CW     = $clog2(G + 1);

  logic [CW-1:0] hits;
  logic          found;

  always_comb begin
    voted = vals[0 +: W];
    found = 1'b0;
    for (int m = 0; m < G; m++) begin
      hits = '0;
      for (int n = 0; n < G; n++)
        hits = hits + CW'(vals[m*W +: W] == vals[n*W +: W]);
      if (!found && (int'(hits) >= QUORUM)) begin
        voted = vals[m*W +: W];
        found = 1'b1;
      end
    end
    for (int m = 0; m < G; m++)
      disagree[m] = (vals[m*W +: W] != voted);
  end

endmodule

// File: rtl/rra_array.sv
module rra_array
  import rra_pkg::*;
#(
  parameter int ROWS  = 2,
  parameter int COLS  = 12,
  parameter int DW    = 8,
  parameter int ACC_W = 20,
  parameter int LEN_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [1:0]            op_mode,
  input  logic [LEN_W-1:0]      len,
  input  logic [ROWS*DW-1:0]    row_a,
  input  logic [COLS*DW-1:0]    col_b,
  input  logic [ROWS*COLS-1:0]  inject,
  output logic                  busy,
  output logic                  done,
  output logic [$clog2(ROWS*COLS+1)-1:0] res_count,
  output logic [ROWS*COLS*ACC_W-1:0]     results,
  output logic [ROWS*COLS/2-1:0]         pair_err,
  output logic [ROWS*COLS-1:0]           elem_dis
);

  localparam int NPE   = ROWS * COLS;
  localparam int NPAIR = NPE / 2;
  localparam int NTRIO = NPE / 3;
  localparam int NQUAD = NPE / 4;
  localparam int CNT_W = $clog2(NPE + 1);

  rra_mode_e mode_q;
  logic      start_acc;
  logic      pe_en;

  rra_ctrl #(.LEN_W(LEN_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .op_mode(op_mode), .len(len),
    .mode_q(mode_q), .start_acc(start_acc), .pe_en(pe_en),
    .busy(busy), .done(done)
  );

  // ---------------- element grid with operand-sharing buses ----------------
  logic [DW-1:0]      a_q   [NPE];
  logic [DW-1:0]      b_q   [NPE];
  logic [DW-1:0]      a_src [NPE];
  logic [DW-1:0]      b_src [NPE];
  logic [DW-1:0]      a_tap [ROWS][COLS+1];
  logic [NPE*ACC_W-1:0] acc_flat;

  for (genvar i = 0; i < ROWS; i++) begin : g_row
    assign a_tap[i][0] = row_a[i*DW +: DW];
    for (genvar j = 0; j < COLS; j++) begin : g_col
      localparam int P = i * COLS + j;
      assign a_tap[i][j+1] = a_q[P];

      // row bus: every member takes the operand entering its group's lead
      always_comb begin
        case (mode_q)
          MD_PAIR: a_src[P] = a_tap[i][j - (j % 2)];
          MD_TRIO: a_src[P] = a_tap[i][j - (j % 3)];
          MD_QUAD: a_src[P] = a_tap[i][j - (j % 4)];
          default: a_src[P] = a_tap[i][j];
        endcase
      end

      // column bus: top row picks the logical column input of its group
      if (i == 0) begin : g_top
        always_comb begin
          case (mode_q)
            MD_PAIR: b_src[P] = col_b[(j / 2) * DW +: DW];
            MD_TRIO: b_src[P] = col_b[(j / 3) * DW +: DW];
            MD_QUAD: b_src[P] = col_b[(j / 4) * DW +: DW];
            default: b_src[P] = col_b[j * DW +: DW];
          endcase
        end
      end else begin : g_inner
        assign b_src[P] = b_q[P - COLS];
      end

      rra_pe #(.DW(DW), .ACC_W(ACC_W)) u_pe (
        .clk(clk), .rst_n(rst_n), .clr(start_acc), .en(pe_en),
        .flip(inject[P]), .a_in(a_src[P]), .b_in(b_src[P]),
        .a_q(a_q[P]), .b_q(b_q[P]), .acc(acc_flat[P*ACC_W +: ACC_W])
      );
    end
  end

  // ---------------- comparators and voters ----------------
  logic [ACC_W-1:0] pair_val [NPE];
  logic [ACC_W-1:0] trio_val [NPE];
  logic [ACC_W-1:0] quad_val [NPE];
  logic [NPE-1:0]   pair_dis;
  logic [NPE-1:0]   trio_dis;
  logic [NPE-1:0]   quad_dis;
  logic [NPAIR-1:0] pair_raw;

  for (genvar g = 0; g < NPAIR; g++) begin : g_pair
    rra_voter #(.G(2), .W(ACC_W)) u_cmp (
      .vals(acc_flat[g*2*ACC_W +: 2*ACC_W]),
      .voted(pair_val[g]), .disagree(pair_dis[g*2 +: 2]));
    assign pair_raw[g] = |pair_dis[g*2 +: 2];
  end
  for (genvar g = 0; g < NTRIO; g++) begin : g_trio
    rra_voter #(.G(3), .W(ACC_W)) u_vote (
      .vals(acc_flat[g*3*ACC_W +: 3*ACC_W]),
      .voted(trio_val[g]), .disagree(trio_dis[g*3 +: 3]));
  end
  for (genvar g = 0; g < NQUAD; g++) begin : g_quad
    rra_voter #(.G(4), .W(ACC_W)) u_vote (
      .vals(acc_flat[g*4*ACC_W +: 4*ACC_W]),
      .voted(quad_val[g]), .disagree(quad_dis[g*4 +: 4]));
  end
  for (genvar s = NPAIR; s < NPE; s++) begin : g_pair_pad
    assign pair_val[s] = '0;
  end
  for (genvar s = NTRIO; s < NPE; s++) begin : g_trio_pad
    assign trio_val[s] = '0;
  end
  for (genvar s = NQUAD; s < NPE; s++) begin : g_quad_pad
    assign quad_val[s] = '0;
  end

  // ---------------- result slots in group order ----------------
  for (genvar s = 0; s < NPE; s++) begin : g_slot
    always_comb begin
      case (mode_q)
        MD_PAIR: results[s*ACC_W +: ACC_W] = pair_val[s];
        MD_TRIO: results[s*ACC_W +: ACC_W] = trio_val[s];
        MD_QUAD: results[s*ACC_W +: ACC_W] = quad_val[s];
        default: results[s*ACC_W +: ACC_W] = acc_flat[s*ACC_W +: ACC_W];
      endcase
    end
  end

  always_comb begin
    case (mode_q)
      MD_PAIR: res_count = CNT_W'(NPAIR);
      MD_TRIO: res_count = CNT_W'(NTRIO);
      MD_QUAD: res_count = CNT_W'(NQUAD);
      default: res_count = CNT_W'(NPE);
    endcase
  end

  // ---------------- sticky flags ----------------
  always_ff @(posedge clk) begin
    if (!rst_n || start_acc) begin
      pair_err <= '0;
      elem_dis <= '0;
    end else begin
      case (mode_q)
        MD_PAIR: pair_err <= pair_err | pair_raw;
        MD_TRIO: elem_dis <= elem_dis | trio_dis;
        MD_QUAD: elem_dis <= elem_dis | quad_dis;
        default: ;
      endcase
    end
  end

  // R4: pair flags only fall at an accepted start
  assert_pair_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(start_acc) |-> ((pair_err & $past(pair_err)) == $past(pair_err)));

  // R3: a dual layer never names single elements
  assert_dual_no_elem_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MD_PAIR) |-> (elem_dis == '0));

  // R2: an unprotected layer raises no flag
  assert_full_no_flags_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MD_FULL) |-> (pair_err == '0 && elem_dis == '0));

  // R8: a launch leaves every sum and flag at zero
  assert_launch_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(start_acc) |-> (acc_flat == '0 && pair_err == '0 && elem_dis == '0));

  // R10: slots beyond the group count stay empty in the smallest grouping
  assert_quad_tail_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MD_QUAD) |-> (results[NPE*ACC_W-1 : NQUAD*ACC_W] == '0));

endmodule

// File: tb/rra_array_test.sv
`timescale 1ns/1ps
module rra_array_test;

  localparam int ROWS = 2, COLS = 12, DW = 8, ACC_W = 20, LEN_W = 8;
  localparam int NPE = ROWS * COLS, NPAIR = NPE / 2, KMAX = 6;
  localparam int AMASK = (1 << ACC_W) - 1;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [1:0] op_mode = '0;
  logic [LEN_W-1:0] len = '0;
  logic [ROWS*DW-1:0] row_a = '0;
  logic [COLS*DW-1:0] col_b = '0;
  logic [NPE-1:0] inject = '0;
  logic busy, done;
  logic [4:0] res_count;
  logic [NPE*ACC_W-1:0] results;
  logic [NPAIR-1:0] pair_err;
  logic [NPE-1:0] elem_dis;

  rra_array #(.ROWS(ROWS), .COLS(COLS), .DW(DW), .ACC_W(ACC_W), .LEN_W(LEN_W)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .op_mode(op_mode), .len(len),
    .row_a(row_a), .col_b(col_b), .inject(inject), .busy(busy), .done(done),
    .res_count(res_count), .results(results), .pair_err(pair_err), .elem_dis(elem_dis));

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0;
  int A [ROWS][KMAX];
  int B [KMAX][COLS];
  logic [NPE-1:0] inj [32];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // value held by a strict-majority quorum, else the first member
  function automatic int bvote(input int v [4], input int g);
    int need = g / 2 + 1;
    for (int m = 0; m < g; m++) begin
      int same = 0;
      for (int q = 0; q < g; q++) if (v[q] == v[m]) same++;
      if (same >= need) return v[m];
    end
    return v[0];
  endfunction

  function automatic string mode_tag(input int md);
    case (md)
      1: return "R3";
      2: return "R5";
      3: return "R6";
      default: return "R2";
    endcase
  endfunction

  task automatic clear_faults();
    for (int t = 0; t < 32; t++) inj[t] = '0;
  endtask

  task automatic rand_data(input int kl);
    for (int i = 0; i < ROWS; i++) for (int k = 0; k < KMAX; k++) A[i][k] = $urandom % 256;
    for (int k = 0; k < KMAX; k++) for (int c = 0; c < COLS; c++) B[k][c] = $urandom % 256;
  endtask

  task automatic run_layer(input int md, input int kl, input int extra);
    int g, lc, L, ngrp;
    int acc_m [NPE];
    bit ep [NPAIR];
    bit ed [NPE];
    bit faulty;
    int v [4];
    g = md + 1;
    lc = COLS / g;
    ngrp = NPE / g;
    L = kl + ROWS + lc - 2 + extra;
    faulty = 1'b0;
    for (int t = 0; t < L; t++) if (inj[t] != '0) faulty = 1'b1;

    @(negedge clk);
    start = 1'b1; op_mode = 2'(md); len = LEN_W'(L);
    row_a = '0; col_b = '0; inject = '0;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R9 busy after start", int'(busy), 1);
    for (int t = 0; t < L; t++) begin
      for (int i = 0; i < ROWS; i++)
        row_a[i*DW +: DW] = (t - i >= 0 && t - i < kl) ? DW'(A[i][t-i]) : '0;
      for (int c = 0; c < COLS; c++)
        if (c < lc) col_b[c*DW +: DW] = (t - c >= 0 && t - c < kl) ? DW'(B[t-c][c]) : '0;
        else col_b[c*DW +: DW] = DW'($urandom);   // ignored columns carry junk
      inject = inj[t];
      op_mode = 2'($urandom);                       // R7: must not matter
      start = (t == 1);                             // R7: ignored while busy
      @(negedge clk);
    end
    start = 1'b0; row_a = '0; col_b = '0; inject = '0;
    chk(done == 1'b0, "R9 done early", int'(done), 0);
    @(negedge clk);
    chk(done == 1'b1, "R9 done timing", int'(done), 1);

    // bench model of every element, beat by beat
    for (int p = 0; p < NPE; p++) begin acc_m[p] = 0; ed[p] = 0; end
    for (int q = 0; q < NPAIR; q++) ep[q] = 0;
    for (int t = 0; t < L; t++) begin
      for (int i = 0; i < ROWS; i++)
        for (int j = 0; j < COLS; j++) begin
          int p = i * COLS + j;
          int c = j / g;
          int k = t - i - c;
          int prod = (k >= 0 && k < kl) ? A[i][k] * B[k][c] : 0;
          if (inj[t][p]) prod = prod ^ 1;
          acc_m[p] = (acc_m[p] + prod) & AMASK;
        end
      if (md == 1)
        for (int q = 0; q < NPAIR; q++) if (acc_m[2*q] != acc_m[2*q+1]) ep[q] = 1;
      if (md >= 2)
        for (int q = 0; q < ngrp; q++) begin
          int vv;
          for (int m = 0; m < 4; m++) v[m] = (m < g) ? acc_m[q*g+m] : 0;
          vv = bvote(v, g);
          for (int m = 0; m < g; m++) if (acc_m[q*g+m] != vv) ed[q*g+m] = 1;
        end
    end

    chk(int'(res_count) == ngrp, "R10 res_count / R7 mode capture", int'(res_count), ngrp);
    for (int s = 0; s < NPE; s++) begin
      int e, a;
      if (s < ngrp) begin
        for (int m = 0; m < 4; m++) v[m] = (m < g) ? acc_m[s*g+m] : 0;
        e = (g == 1) ? acc_m[s] : bvote(v, g);
      end else e = 0;
      a = int'(results[s*ACC_W +: ACC_W]);
      if (s == 0) chk(a == e, "R8 slot 0 fresh sum", a, e);
      else if (s >= ngrp) chk(a == e, "R10 unused slot", a, e);
      else chk(a == e, mode_tag(md), a, e);
    end
    for (int q = 0; q < NPAIR; q++)
      chk(pair_err[q] == ep[q], faulty ? "R11 pair flag" : "R4 pair flag", int'(pair_err[q]), int'(ep[q]));
    for (int p = 0; p < NPE; p++)
      chk(elem_dis[p] == ed[p], faulty ? "R11 element flag" : mode_tag(md), int'(elem_dis[p]), int'(ed[p]));
    @(negedge clk);
    chk(done == 1'b0, "R9 done pulse width", int'(done), 0);
  endtask

  task automatic ones_data();
    for (int i = 0; i < ROWS; i++) for (int k = 0; k < KMAX; k++) A[i][k] = 1;
    for (int k = 0; k < KMAX; k++) for (int c = 0; c < COLS; c++) B[k][c] = 1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    clear_faults();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(busy == 1'b0, "R1 busy", int'(busy), 0);
    chk(done == 1'b0, "R1 done", int'(done), 0);
    chk(results == '0, "R1 results", 0, 0);
    chk(pair_err == '0 && elem_dis == '0, "R1 flags", int'(pair_err), 0);
    chk(int'(res_count) == NPE, "R1 res_count", int'(res_count), NPE);

    // fault-free pass through every grouping
    for (int md = 0; md < 4; md++) begin
      rand_data(KMAX);
      run_layer(md, KMAX, 0);
    end

    // R4: pair fault that cancels itself (-1 on a real term, +1 on an empty beat)
    ones_data();
    clear_faults();
    inj[0][1] = 1'b1;
    inj[3][1] = 1'b1;
    run_layer(1, 3, 0);

    // R5: single outvoted member in triple group 1
    rand_data(4);
    clear_faults();
    inj[2][4] = 1'b1;
    run_layer(2, 4, 1);

    // R6: quad group 0 with two different faults, no three-way quorum
    ones_data();
    clear_faults();
    inj[0][1] = 1'b1;
    inj[0][2] = 1'b1;
    inj[1][2] = 1'b1;
    run_layer(3, 3, 0);

    // R6: single spare fault is outvoted
    rand_data(5);
    clear_faults();
    inj[3][7] = 1'b1;
    run_layer(3, 5, 2);

    // mixed random layers, flags and sums must not leak between them (R8)
    for (int n = 0; n < 40; n++) begin
      int md = $urandom % 4;
      int kl = 1 + $urandom % KMAX;
      rand_data(kl);
      clear_faults();
      if ($urandom % 3 == 0) inj[$urandom % (kl + 2)][$urandom % NPE] = 1'b1;
      run_layer(md, kl, $urandom % 3);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule